// File: doc/BRIEF.md
# Power State Sequencing Controller

This block keeps track of which of three power modes a small system is in: Operating, where every clock runs; Idle, where only the processor clock is stopped; and Standby, where the main oscillator is also stopped, the external address and data buses are held low and the peripherals are held in reset. Software moves the system out of Operating by pulsing one of two write strobes, one requesting Idle and one requesting Standby. Hardware events move it back or force it down.

Slow external event lines are filtered before use: wake-up, active-low power fail, battery good, active-low external power present and keyboard. They are sampled on an enable that is derived inside the block from the system clock every `SAMPLE_DIV` cycles. A line's filtered value changes only after two sample points in a row agree. Enabled interrupts arrive as a synchronous level and need no filtering. A configuration input picks how the status pin behaves. In one mode the pin is always driven and shows whether the system is awake. In the other mode the pin is driven, low, only during Standby.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While and after a synchronous reset the block is in Operating: `cpu_clk_en`=1, `osc_en`=1, `bus_force_low`=0, `periph_rst`=0, `status_pin`=1, `status_oe`=1, `fiq_batlow`=0.
- R2: A `wr_halt` pulse in Operating gives Idle at the next clock edge (`cpu_clk_en`=0, `osc_en`=1). `wr_halt` has no effect in Idle or Standby.
- R3: In Idle, an `irq` level or a filtered high `kbd_in` returns the block to Operating at the next clock edge.
- R4: A `wr_standby` pulse in Operating or Idle gives Standby at the next clock edge: `cpu_clk_en`=0, `osc_en`=0, `bus_force_low`=1, `periph_rst`=1.
- R5: In Standby, a low-to-high change of filtered `wake_in` returns the block to Operating. This happens only if filtered `bat_ok` is 1 or filtered `ext_pwr_n` is 0. `irq` has no effect in Standby.
- R6: In Standby, with filtered `bat_ok`=0 and filtered `ext_pwr_n`=1, a wake-up edge is ignored and the block stays in Standby.
- R7: The wake-up filter leaves reset at 1. A `wake_in` held high through reset therefore produces no edge. Only a fall followed by a rise after reset counts.
- R8: A filtered `pwr_fail_n`=0 forces Standby from any state at the next edge. While it stays low, no wake-up edge leaves Standby.
- R9: Each event line is sampled once every `SAMPLE_DIV` clocks. Its filtered value changes only when two successive samples agree. A pulse shorter than `SAMPLE_DIV` clocks has no effect. A change takes at least `SAMPLE_DIV`+2 clocks and at most 2×`SAMPLE_DIV`+1 clocks to reach the state outputs.
- R10: A high-to-low change of filtered `bat_ok` outside Standby raises `fiq_batlow` for exactly one cycle. The same change during Standby raises nothing.
- R11: With `clken_sel`=0 the status pin is always driven (`status_oe`=1) and `status_pin` is 0 only in Standby. With `clken_sel`=1, `status_oe` is 1 only in Standby, and then `status_pin` is 0. Both outputs follow `clken_sel` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_halt | input | 1 | Write strobe requesting Idle |
| wr_standby | input | 1 | Write strobe requesting Standby |
| irq | input | 1 | Any enabled interrupt pending (synchronous level) |
| wake_in | input | 1 | Wake-up event line, filtered |
| pwr_fail_n | input | 1 | Power fail, active low, filtered |
| bat_ok | input | 1 | Main battery good, filtered |
| ext_pwr_n | input | 1 | External supply present, active low, filtered |
| kbd_in | input | 1 | Key pressed, filtered |
| clken_sel | input | 1 | Status pin mode: 0 awake indicator, 1 drive-low-in-Standby |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Main oscillator enable |
| bus_force_low | output | 1 | Hold external address and data buses low |
| periph_rst | output | 1 | Hold peripherals in reset |
| status_pin | output | 1 | Status pin output value |
| status_oe | output | 1 | Status pin output enable |
| fiq_batlow | output | 1 | One-cycle fast interrupt request on battery drop |

## Verification
A strobe or `irq` is applied for one cycle, and its result is due on the outputs right after the next rising edge. The bench checks that cycle directly.

A change on a filtered line reaches the outputs between `SAMPLE_DIV`+2 and 2×`SAMPLE_DIV`+1 edges later. The exact time depends on where the sample point falls. The bench therefore checks that nothing has moved `SAMPLE_DIV` cycles after the change, and checks the final value 2×`SAMPLE_DIV`+3 cycles after it. The battery interrupt is counted edge by edge over the whole settling window, so both its width and the number of pulses are checked.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_OPER = 2'd0,
    PS_IDLE = 2'd1,
    PS_STBY = 2'd2
  } pwr_state_t;

  // positions of the filtered event lines
  localparam int EV_WAKE  = 0;
  localparam int EV_PFN   = 1;
  localparam int EV_BATOK = 2;
  localparam int EV_EXTN  = 3;
  localparam int EV_KBD   = 4;
  localparam int EV_COUNT = 5;

  // values the filters hold out of reset: wake, power fail, battery and
  // external power read as inactive-high, keyboard as released
  localparam logic [EV_COUNT-1:0] EV_RESET = 5'b01111;
endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/pwr_deglitch.sv
module pwr_deglitch #(
  parameter int               W       = 5,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] raw,
  output logic [W-1:0] flt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic smp;
    logic val;

    // a new level is taken only when the current sample matches the last one
    always_ff @(posedge clk) begin
      if (rst) begin
        smp <= RST_VAL[i];
        val <= RST_VAL[i];
      end else if (tick) begin
        smp <= raw[i];
        if (raw[i] == smp) val <= raw[i];
      end
    end

    assign flt[i] = val;
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_halt,
  input  logic                wr_standby,
  input  logic                irq,
  input  logic [EV_COUNT-1:0] ev_flt,
  input  logic                clken_sel,
  output logic                cpu_clk_en,
  output logic                osc_en,
  output logic                bus_force_low,
  output logic                periph_rst,
  output logic                status_pin,
  output logic                status_oe,
  output logic                fiq_batlow
);
  pwr_state_t state, nxt;
  logic wake_q, bat_q;
  logic wake_rise, bat_fall, supply_ok, pf_active, kbd_act;

  assign wake_rise = ev_flt[EV_WAKE] & ~wake_q;
  assign bat_fall  = bat_q & ~ev_flt[EV_BATOK];
  assign supply_ok = ev_flt[EV_BATOK] | ~ev_flt[EV_EXTN];
  assign pf_active = ~ev_flt[EV_PFN];
  assign kbd_act   = ev_flt[EV_KBD];

  always_comb begin
    nxt = state;
    if (pf_active) begin
      nxt = PS_STBY;
    end else begin
      unique case (state)
        PS_OPER: begin
          if (wr_standby)   nxt = PS_STBY;
          else if (wr_halt) nxt = PS_IDLE;
        end
        PS_IDLE: begin
          if (wr_standby)          nxt = PS_STBY;
          else if (irq || kbd_act) nxt = PS_OPER;
        end
        PS_STBY: begin
          if (wake_rise && supply_ok) nxt = PS_OPER;
        end
        default: nxt = PS_OPER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= PS_OPER;
      cpu_clk_en    <= 1'b1;
      osc_en        <= 1'b1;
      bus_force_low <= 1'b0;
      periph_rst    <= 1'b0;
      status_pin    <= 1'b1;
      status_oe     <= 1'b1;
      fiq_batlow    <= 1'b0;
      wake_q        <= EV_RESET[EV_WAKE];
      bat_q         <= EV_RESET[EV_BATOK];
    end else begin
      state         <= nxt;
      cpu_clk_en    <= (nxt == PS_OPER);
      osc_en        <= (nxt != PS_STBY);
      bus_force_low <= (nxt == PS_STBY);
      periph_rst    <= (nxt == PS_STBY);
      status_pin    <= (nxt != PS_STBY);
      status_oe     <= ~clken_sel | (nxt == PS_STBY);
      fiq_batlow    <= bat_fall & (state != PS_STBY);
      wake_q        <= ev_flt[EV_WAKE];
      bat_q         <= ev_flt[EV_BATOK];
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SAMPLE_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_halt,
  input  logic wr_standby,
  input  logic irq,
  input  logic wake_in,
  input  logic pwr_fail_n,
  input  logic bat_ok,
  input  logic ext_pwr_n,
  input  logic kbd_in,
  input  logic clken_sel,
  output logic cpu_clk_en,
  output logic osc_en,
  output logic bus_force_low,
  output logic periph_rst,
  output logic status_pin,
  output logic status_oe,
  output logic fiq_batlow
);
  logic                sample_en;
  logic [EV_COUNT-1:0] ev_raw;
  logic [EV_COUNT-1:0] ev_flt;
  logic                pf_n_flt;

  always_comb begin
    ev_raw           = '0;
    ev_raw[EV_WAKE]  = wake_in;
    ev_raw[EV_PFN]   = pwr_fail_n;
    ev_raw[EV_BATOK] = bat_ok;
    ev_raw[EV_EXTN]  = ext_pwr_n;
    ev_raw[EV_KBD]   = kbd_in;
  end

  assign pf_n_flt = ev_flt[EV_PFN];

  pwr_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_en)
  );

  pwr_deglitch #(.W(EV_COUNT), .RST_VAL(EV_RESET)) u_flt (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_en),
    .raw  (ev_raw),
    .flt  (ev_flt)
  );

  pwr_state_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .wr_halt       (wr_halt),
    .wr_standby    (wr_standby),
    .irq           (irq),
    .ev_flt        (ev_flt),
    .clken_sel     (clken_sel),
    .cpu_clk_en    (cpu_clk_en),
    .osc_en        (osc_en),
    .bus_force_low (bus_force_low),
    .periph_rst    (periph_rst),
    .status_pin    (status_pin),
    .status_oe     (status_oe),
    .fiq_batlow    (fiq_batlow)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic wr_halt,
  input logic wr_standby,
  input logic irq,
  input logic pf_ok,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic bus_force_low,
  input logic periph_rst,
  input logic status_pin,
  input logic status_oe,
  input logic fiq_batlow
);
  AST_HALT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && wr_halt && !wr_standby && pf_ok) |=> (!cpu_clk_en && osc_en)); // R2
  AST_IRQ_RESUME: assert property (@(posedge clk) disable iff (rst)
    (osc_en && !cpu_clk_en && irq && !wr_standby && pf_ok) |=> cpu_clk_en); // R3
  AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (osc_en && wr_standby) |=> !osc_en); // R4
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (bus_force_low && periph_rst && !cpu_clk_en)); // R4
  AST_PWR_FAIL: assert property (@(posedge clk) disable iff (rst)
    !pf_ok |=> !osc_en); // R8
  AST_FIQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fiq_batlow |=> !fiq_batlow); // R10
  AST_FIQ_AWAKE: assert property (@(posedge clk) disable iff (rst)
    fiq_batlow |-> $past(osc_en)); // R10
  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !status_oe |-> (status_pin && osc_en)); // R11
endmodule

bind pwr_seq_ctrl pwr_seq_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_halt       (wr_halt),
  .wr_standby    (wr_standby),
  .irq           (irq),
  .pf_ok         (pf_n_flt),
  .cpu_clk_en    (cpu_clk_en),
  .osc_en        (osc_en),
  .bus_force_low (bus_force_low),
  .periph_rst    (periph_rst),
  .status_pin    (status_pin),
  .status_oe     (status_oe),
  .fiq_batlow    (fiq_batlow)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int DIV    = 16;
  localparam int SETTLE = 2 * DIV + 3;
  localparam int ST_OP = 0, ST_ID = 1, ST_SB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_halt = 0, wr_standby = 0, irq = 0;
  logic wake_in = 0, pwr_fail_n = 1, bat_ok = 1, ext_pwr_n = 1, kbd_in = 0;
  logic clken_sel = 0;
  logic cpu_clk_en, osc_en, bus_force_low, periph_rst, status_pin, status_oe, fiq_batlow;

  int checks = 0;
  int errors = 0;
  int fiq_cnt = 0;
  int model;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.SAMPLE_DIV(DIV)) i_pwr_seq_ctrl (
    .clk(clk), .rst(rst), .wr_halt(wr_halt), .wr_standby(wr_standby), .irq(irq),
    .wake_in(wake_in), .pwr_fail_n(pwr_fail_n), .bat_ok(bat_ok), .ext_pwr_n(ext_pwr_n),
    .kbd_in(kbd_in), .clken_sel(clken_sel), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .bus_force_low(bus_force_low), .periph_rst(periph_rst), .status_pin(status_pin),
    .status_oe(status_oe), .fiq_batlow(fiq_batlow)
  );

  always @(posedge clk) if (!rst && fiq_batlow) fiq_cnt++;

  function automatic int nx(int st, bit h, bit s, bit i);
    case (st)
      ST_OP:   return s ? ST_SB : (h ? ST_ID : ST_OP);
      ST_ID:   return s ? ST_SB : (i ? ST_OP : ST_ID);
      default: return ST_SB;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int st);
    chk({tag, " cpu_clk_en"}, int'(cpu_clk_en), int'(st == ST_OP));
    chk({tag, " osc_en"}, int'(osc_en), int'(st != ST_SB));
    chk({tag, " bus_force_low"}, int'(bus_force_low), int'(st == ST_SB));
    chk({tag, " periph_rst"}, int'(periph_rst), int'(st == ST_SB));
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_halt();
    wr_halt = 1; cyc(1); wr_halt = 0;
  endtask

  task automatic pulse_stby();
    wr_standby = 1; cyc(1); wr_standby = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'h5EED_2024));
    cyc(3);
    // R1 reset values, during and after reset
    chk_state("R1 in reset", ST_OP);
    chk("R1 status_pin", int'(status_pin), 1);
    chk("R1 status_oe", int'(status_oe), 1);
    chk("R1 fiq", int'(fiq_batlow), 0);
    rst = 0;
    cyc(SETTLE);
    chk_state("R1 after reset", ST_OP);

    // R2 halt, then ignored in Idle; R3 irq resumes
    pulse_halt();
    chk_state("R2 halt to idle", ST_ID);
    pulse_halt();
    chk_state("R2 halt ignored in idle", ST_ID);
    irq = 1; cyc(1); irq = 0;
    chk_state("R3 irq resume", ST_OP);

    // R9 short keyboard pulse rejected, R3 keyboard resume with minimum latency
    pulse_halt();
    kbd_in = 1; cyc(DIV - 1); kbd_in = 0;
    cyc(SETTLE);
    chk_state("R9 short pulse ignored", ST_ID);
    kbd_in = 1; cyc(DIV);
    chk_state("R9 not before two samples", ST_ID);
    cyc(DIV + 3);
    chk_state("R3 keyboard resume", ST_OP);
    kbd_in = 0; cyc(SETTLE);

    // R4 standby entry and outputs; R2/R5 ignored inputs in standby
    pulse_stby();
    chk_state("R4 standby entry", ST_SB);
    chk("R11 run mode pin low", int'(status_pin), 0);
    chk("R11 run mode oe", int'(status_oe), 1);
    pulse_halt();
    irq = 1; cyc(3); irq = 0;
    chk_state("R5 halt and irq ignored in standby", ST_SB);
    wake_in = 1; cyc(SETTLE);
    chk_state("R5 wake edge resumes", ST_OP);
    wake_in = 0; cyc(SETTLE);

    // R4 standby from idle
    pulse_halt();
    pulse_stby();
    chk_state("R4 standby from idle", ST_SB);

    // R6 battery low blocks wake; R10 no fiq in standby
    f0 = fiq_cnt;
    bat_ok = 0; cyc(SETTLE);
    chk("R10 no fiq in standby", fiq_cnt - f0, 0);
    wake_in = 1; cyc(SETTLE);
    chk_state("R6 wake inhibited on low battery", ST_SB);
    wake_in = 0; ext_pwr_n = 0; cyc(SETTLE);
    wake_in = 1; cyc(SETTLE);
    chk_state("R5 wake on external power", ST_OP);
    wake_in = 0; ext_pwr_n = 1; bat_ok = 1; cyc(SETTLE);

    // R10 battery drop while running
    f0 = fiq_cnt;
    bat_ok = 0; cyc(SETTLE);
    chk("R10 single fiq cycle", fiq_cnt - f0, 1);
    chk_state("R10 state kept", ST_OP);
    bat_ok = 1; cyc(SETTLE);
    chk("R10 no fiq on rise", fiq_cnt - f0, 1);

    // R8 power fail forces standby and blocks wake
    pulse_halt();
    pwr_fail_n = 0; cyc(SETTLE);
    chk_state("R8 power fail from idle", ST_SB);
    wake_in = 1; cyc(SETTLE);
    chk_state("R8 wake blocked during power fail", ST_SB);
    pwr_fail_n = 1; cyc(SETTLE);
    chk_state("R8 stays down after recovery", ST_SB);
    wake_in = 0; cyc(SETTLE);
    wake_in = 1; cyc(SETTLE);
    chk_state("R8 later wake resumes", ST_OP);

    // R7 wake high through reset gives no edge
    rst = 1; cyc(3); rst = 0;
    cyc(SETTLE);
    pulse_stby();
    cyc(SETTLE);
    chk_state("R7 held wake ignored", ST_SB);
    wake_in = 0; cyc(SETTLE);
    wake_in = 1; cyc(SETTLE);
    chk_state("R7 fresh wake edge", ST_OP);

    // R11 clock-enable pin mode
    clken_sel = 1; cyc(2);
    chk("R11 clken oe awake", int'(status_oe), 0);
    chk("R11 clken pin awake", int'(status_pin), 1);
    pulse_stby();
    chk("R11 clken oe standby", int'(status_oe), 1);
    chk("R11 clken pin standby", int'(status_pin), 0);
    wake_in = 0; cyc(SETTLE);
    wake_in = 1; cyc(SETTLE);
    chk("R11 clken oe after wake", int'(status_oe), 0);
    clken_sel = 0; cyc(2);
    chk("R11 run oe restored", int'(status_oe), 1);

    // random strobes against the bench model (R2 R3 R4 R5)
    model = ST_OP;
    for (int n = 0; n < 400; n++) begin
      if (model == ST_SB) begin
        wake_in = 0; cyc(SETTLE);
        wake_in = 1; cyc(SETTLE);
        model = ST_OP;
        chk_state("R5 random wake", model);
      end else begin
        bit h, s, i;
        h = ($urandom % 5) == 0;
        s = ($urandom % 12) == 0;
        i = ($urandom % 4) == 0;
        wr_halt = h; wr_standby = s; irq = i;
        cyc(1);
        wr_halt = 0; wr_standby = 0; irq = 0;
        model = nx(model, h, s, i);
        chk_state("R2 R3 R4 random", model);
      end
    end

    finish_run();
  end
endmodule